// File: doc/BRIEF.md
# Stripmining Loop Length Sequencer

This block breaks a long vector loop of N elements into pieces that fit the vector register length, so a downstream vector datapath can run the loop one chunk at a time. A command brings the total element count and three base byte addresses: two source operand arrays and one result array. The sequencer then presents a run of chunks. Each chunk carries a vector length and the current value of all three addresses. It waits for the consumer to accept a chunk before it moves on.

The leftover piece is issued first. Its length is the low bits of N, taken modulo the maximum vector length. Every chunk after it is full length. After each accepted chunk, every address moves forward by the chunk length times the element size in bytes, and the remaining count drops by the same length. When nothing remains, a one-cycle completion pulse is raised and the sequencer becomes ready for the next command. A count that is an exact multiple of the maximum length produces no empty chunk. A count of zero completes without issuing any chunk.

Top module: `stripmine_seq`

## Requirements
- R1: After synchronous reset, cmd_ready_o is 1 and chunk_valid_o and done_o are both 0.
- R2: For a command with N mod 64 nonzero, the first chunk's length equals N mod 64, which is the value of the low 6 bits of N.
- R3: Every chunk after the first has length 64 (the maximum vector length).
- R4: When N is a nonzero multiple of 64, no zero-length chunk is issued, and the first chunk already has length 64.
- R5: Each chunk presents, for each of the three addresses independently, its base plus 8 times the sum of the lengths of all earlier chunks of the same command, modulo 2^32.
- R6: While chunk_valid_o is 1 and chunk_ready_i is 0, the length and all three addresses are held and the chunk stays valid.
- R7: The cycle after the last chunk is accepted, done_o is 1 for exactly one cycle. The accepted chunk lengths of a command add up to N.
- R8: A command with N equal to 0 issues no chunk, and done_o rises in the cycle after the command is accepted.
- R9: A command is accepted only when cmd_start_i and cmd_ready_o are both 1. cmd_ready_o is 0 from acceptance until done_o has been shown, and a start request in that window has no effect on the chunks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cmd_start_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Sequencer idle, command accepted this cycle if requested |
| cmd_len_i | input | LEN_W (16) | Total element count N |
| cmd_base_a_i | input | ADDR_W (32) | First source base address |
| cmd_base_b_i | input | ADDR_W (32) | Second source base address |
| cmd_base_c_i | input | ADDR_W (32) | Result base address |
| chunk_valid_o | output | 1 | A chunk is presented |
| chunk_ready_i | input | 1 | Consumer accepts the presented chunk |
| chunk_len_o | output | VL_W (7) | Vector length of the chunk |
| chunk_ptr_a_o | output | ADDR_W (32) | First source address for the chunk |
| chunk_ptr_b_o | output | ADDR_W (32) | Second source address for the chunk |
| chunk_ptr_c_o | output | ADDR_W (32) | Result address for the chunk |
| done_o | output | 1 | One-cycle pulse when the command has finished |

## Verification
The bench targets the following corner cases:
- Counts of 0, 1, 63, 64, 65, 128 and others with both zero and nonzero low bits. A design that skipped the remainder test would issue a zero-length chunk for exact multiples. A design that reloaded the wrong length would keep issuing short chunks or overrun N, and the sum check at completion would catch either.
- Random stalls on the consumer side. A design that advanced on valid alone would move the addresses while a chunk was still waiting.
- Start requests raised in the middle of a run. A design that accepted them would jump to new bases or counts.
- Long runs that push the addresses across many chunks. An address step of the wrong scale would show up there.

// File: rtl/stripmine_pkg.sv
package stripmine_pkg;

    // Default geometry of the sequencer
    localparam int unsigned DEF_MAX_VL     = 64;
    localparam int unsigned DEF_ELEM_BYTES = 8;
    localparam int unsigned DEF_LEN_W      = 16;
    localparam int unsigned DEF_ADDR_W     = 32;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_ISSUE  = 2'd1,
        SEQ_FINISH = 2'd2
    } seq_state_e;

    // Bytes covered by a chunk of the given element count
    function automatic logic [63:0] chunk_bytes(input logic [31:0] vl,
                                                input logic [31:0] elem);
        return 64'(vl) * 64'(elem);
    endfunction

    // Length of the leading chunk: the remainder, or a full chunk when the
    // remainder is empty (the empty chunk is skipped)
    function automatic logic [31:0] lead_len(input logic [31:0] rem_bits,
                                             input logic [31:0] max_vl);
        return (rem_bits == 32'd0) ? max_vl : rem_bits;
    endfunction

endpackage

// File: rtl/stripmine_count.sv
module stripmine_count
    import stripmine_pkg::*;
#(
    parameter int unsigned LEN_W  = DEF_LEN_W,
    parameter int unsigned MAX_VL = DEF_MAX_VL,
    parameter int unsigned VL_W   = $clog2(MAX_VL) + 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             advance_i,
    output logic [VL_W-1:0]  vl_o,
    output logic             last_o,
    output logic             zero_len_o
);
    localparam int unsigned LOG_VL = $clog2(MAX_VL);

    logic [LEN_W-1:0] remain_q;
    logic [VL_W-1:0]  vl_q;
    logic [31:0]      rem_bits;

    assign rem_bits   = 32'(len_i[LOG_VL-1:0]);
    assign zero_len_o = (len_i == '0);
    assign last_o     = (remain_q == LEN_W'(vl_q));
    assign vl_o       = vl_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            remain_q <= '0;
            vl_q     <= '0;
        end else if (load_i) begin
            remain_q <= len_i;
            vl_q     <= VL_W'(lead_len(rem_bits, 32'(MAX_VL)));
        end else if (advance_i) begin
            remain_q <= remain_q - LEN_W'(vl_q);
            vl_q     <= VL_W'(MAX_VL);
        end
    end

    // R3: once a chunk is taken and more remain, the next one is full length
    a_r3_full_after_first: assert property (@(posedge clk_i) disable iff (rst_i)
        (advance_i && !last_o) |=> (vl_o == VL_W'(MAX_VL)));

    // R2: a nonzero remainder becomes the first length
    a_r2_lead_remainder: assert property (@(posedge clk_i) disable iff (rst_i)
        (load_i && len_i[LOG_VL-1:0] != '0) |=> (vl_o == VL_W'($past(len_i[LOG_VL-1:0]))));

endmodule

// File: rtl/stripmine_ptr.sv
module stripmine_ptr
    import stripmine_pkg::*;
#(
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned VL_W       = 7,
    parameter int unsigned ELEM_BYTES = DEF_ELEM_BYTES
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              advance_i,
    input  logic [VL_W-1:0]   vl_i,
    output logic [ADDR_W-1:0] ptr_o
);
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] step;

    assign step  = ADDR_W'(chunk_bytes(32'(vl_i), 32'(ELEM_BYTES)));
    assign ptr_o = ptr_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)          ptr_q <= '0;
        else if (load_i)    ptr_q <= base_i;
        else if (advance_i) ptr_q <= ptr_q + step;
    end

    // R5: the address only moves on a load or an accepted chunk
    a_r5_ptr_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && !advance_i) |=> $stable(ptr_o));

endmodule

// File: rtl/stripmine_ctrl.sv
module stripmine_ctrl
    import stripmine_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    input  logic zero_len_i,
    input  logic last_i,
    input  logic chunk_ready_i,
    output logic cmd_ready_o,
    output logic chunk_valid_o,
    output logic load_o,
    output logic advance_o,
    output logic done_o
);
    seq_state_e state_q, state_d;

    assign cmd_ready_o   = (state_q == SEQ_IDLE);
    assign chunk_valid_o = (state_q == SEQ_ISSUE);
    assign done_o        = (state_q == SEQ_FINISH);
    assign load_o        = cmd_ready_o && start_i;
    assign advance_o     = chunk_valid_o && chunk_ready_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:   if (start_i) state_d = zero_len_i ? SEQ_FINISH : SEQ_ISSUE;
            SEQ_ISSUE:  if (chunk_ready_i && last_i) state_d = SEQ_FINISH;
            SEQ_FINISH: state_d = SEQ_IDLE;
            default:    state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= SEQ_IDLE;
        else       state_q <= state_d;
    end

    // R8: an empty command goes straight to completion
    a_r8_zero_finishes: assert property (@(posedge clk_i) disable iff (rst_i)
        (load_o && zero_len_i) |=> (done_o && !chunk_valid_o));

    // R7: completion lasts a single cycle and returns to idle
    a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> (!done_o && cmd_ready_o));

endmodule

// File: rtl/stripmine_seq.sv
module stripmine_seq
    import stripmine_pkg::*;
#(
    parameter int unsigned MAX_VL     = DEF_MAX_VL,
    parameter int unsigned ELEM_BYTES = DEF_ELEM_BYTES,
    parameter int unsigned LEN_W      = DEF_LEN_W,
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned VL_W       = $clog2(MAX_VL) + 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cmd_start_i,
    output logic              cmd_ready_o,
    input  logic [LEN_W-1:0]  cmd_len_i,
    input  logic [ADDR_W-1:0] cmd_base_a_i,
    input  logic [ADDR_W-1:0] cmd_base_b_i,
    input  logic [ADDR_W-1:0] cmd_base_c_i,
    output logic              chunk_valid_o,
    input  logic              chunk_ready_i,
    output logic [VL_W-1:0]   chunk_len_o,
    output logic [ADDR_W-1:0] chunk_ptr_a_o,
    output logic [ADDR_W-1:0] chunk_ptr_b_o,
    output logic [ADDR_W-1:0] chunk_ptr_c_o,
    output logic              done_o
);
    localparam int unsigned NPTR = 3;

    logic load, advance, last, zero_len;
    logic [NPTR-1:0][ADDR_W-1:0] bases, ptrs;

    assign bases = {cmd_base_c_i, cmd_base_b_i, cmd_base_a_i};

    stripmine_ctrl u_ctrl (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .start_i       (cmd_start_i),
        .zero_len_i    (zero_len),
        .last_i        (last),
        .chunk_ready_i (chunk_ready_i),
        .cmd_ready_o   (cmd_ready_o),
        .chunk_valid_o (chunk_valid_o),
        .load_o        (load),
        .advance_o     (advance),
        .done_o        (done_o)
    );

    stripmine_count #(.LEN_W(LEN_W), .MAX_VL(MAX_VL), .VL_W(VL_W)) u_count (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (load),
        .len_i      (cmd_len_i),
        .advance_i  (advance),
        .vl_o       (chunk_len_o),
        .last_o     (last),
        .zero_len_o (zero_len)
    );

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        stripmine_ptr #(.ADDR_W(ADDR_W), .VL_W(VL_W), .ELEM_BYTES(ELEM_BYTES)) u_ptr (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .load_i    (load),
            .base_i    (bases[g]),
            .advance_i (advance),
            .vl_i      (chunk_len_o),
            .ptr_o     (ptrs[g])
        );
    end

    assign chunk_ptr_a_o = ptrs[0];
    assign chunk_ptr_b_o = ptrs[1];
    assign chunk_ptr_c_o = ptrs[2];

    // R6: a stalled chunk stays put
    a_r6_hold_stalled: assert property (@(posedge clk_i) disable iff (rst_i)
        (chunk_valid_o && !chunk_ready_i) |=>
            (chunk_valid_o && $stable(chunk_len_o) && $stable(chunk_ptr_a_o)
             && $stable(chunk_ptr_b_o) && $stable(chunk_ptr_c_o)));

    // R9: no command is taken while chunks are outstanding
    a_r9_busy_blocks: assert property (@(posedge clk_i) disable iff (rst_i)
        chunk_valid_o |-> !cmd_ready_o);

    // R3: a presented chunk is never empty and never over the maximum
    a_r3_len_range: assert property (@(posedge clk_i) disable iff (rst_i)
        chunk_valid_o |-> (chunk_len_o != '0 && chunk_len_o <= VL_W'(MAX_VL)));

endmodule

// File: tb/stripmine_seq_tb.sv
module stripmine_seq_tb_top;
    localparam int MAXV = 64;
    localparam int ELEM = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_start_i;
    logic        cmd_ready_o;
    logic [15:0] cmd_len_i;
    logic [31:0] cmd_base_a_i, cmd_base_b_i, cmd_base_c_i;
    logic        chunk_valid_o;
    logic        chunk_ready_i;
    logic [6:0]  chunk_len_o;
    logic [31:0] chunk_ptr_a_o, chunk_ptr_b_o, chunk_ptr_c_o;
    logic        done_o;

    always #2ns clk = ~clk;

    stripmine_seq dut_i (
        .clk_i(clk), .rst_i(rst),
        .cmd_start_i(cmd_start_i), .cmd_ready_o(cmd_ready_o),
        .cmd_len_i(cmd_len_i),
        .cmd_base_a_i(cmd_base_a_i), .cmd_base_b_i(cmd_base_b_i), .cmd_base_c_i(cmd_base_c_i),
        .chunk_valid_o(chunk_valid_o), .chunk_ready_i(chunk_ready_i),
        .chunk_len_o(chunk_len_o),
        .chunk_ptr_a_o(chunk_ptr_a_o), .chunk_ptr_b_o(chunk_ptr_b_o), .chunk_ptr_c_o(chunk_ptr_c_o),
        .done_o(done_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int rdy_mode = 0;
    int cycles   = 0;
    longint dut_sum = 0;
    longint cur_n   = 0;

    // Behavioural reference: 0 idle, 1 issuing, 2 finishing
    int     m_st = 0;
    longint m_rem = 0;
    longint m_vl = 0;
    longint m_ptr [3];

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0;
        end else begin
            case (m_st)
                0: if (cmd_start_i) begin
                    m_rem = cmd_len_i;
                    m_ptr[0] = cmd_base_a_i; m_ptr[1] = cmd_base_b_i; m_ptr[2] = cmd_base_c_i;
                    if (cmd_len_i == 0) m_st = 2;
                    else begin
                        m_vl = cmd_len_i % MAXV;
                        if (m_vl == 0) m_vl = MAXV;
                        m_st = 1;
                    end
                end
                1: if (chunk_ready_i) begin
                    m_rem -= m_vl;
                    for (int k = 0; k < 3; k++) m_ptr[k] = (m_ptr[k] + m_vl * ELEM) % 64'h1_0000_0000;
                    if (m_rem == 0) m_st = 2; else m_vl = MAXV;
                end
                default: m_st = 0;
            endcase
            if (chunk_valid_o && chunk_ready_i) dut_sum += chunk_len_o;
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            check("R9", "cmd_ready", cmd_ready_o, m_st == 0);
            check("R6", "chunk_valid", chunk_valid_o, m_st == 1);
            check("R7", "done", done_o, m_st == 2);
            if (m_st == 1) begin
                check("R3", "chunk_len", chunk_len_o, m_vl);
                check("R5", "ptr_a", chunk_ptr_a_o, m_ptr[0]);
                check("R5", "ptr_b", chunk_ptr_b_o, m_ptr[1]);
                check("R5", "ptr_c", chunk_ptr_c_o, m_ptr[2]);
            end
            if (done_o) check("R7", "sum of lengths", dut_sum, cur_n);
        end
    end

    always @(negedge clk) begin
        chunk_ready_i = (rdy_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic run_cmd(input int n, input int junk);
        @(negedge clk);
        while (!cmd_ready_o) @(negedge clk);
        cur_n = n;
        dut_sum = 0;
        cmd_start_i  = 1'b1;
        cmd_len_i    = 16'(n);
        cmd_base_a_i = $urandom;
        cmd_base_b_i = 32'h1000;
        cmd_base_c_i = 32'hFFFF_FF00;
        @(negedge clk);
        cmd_start_i = 1'b0;
        if (n == 0) check("R8", "done after empty command", done_o, 1);
        else if (n % MAXV != 0) check("R2", "first length", chunk_len_o, n % MAXV);
        else check("R4", "first length for multiple", chunk_len_o, MAXV);
        if (junk != 0) begin
            // R9: requests while busy must be ignored
            cmd_start_i  = 1'b1;
            cmd_len_i    = 16'(junk);
            cmd_base_a_i = 32'hDEAD_0000;
            repeat (3) @(negedge clk);
            cmd_start_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        @(negedge clk);
        check("R7", "done single cycle", done_o, 0);
    endtask

    initial begin
        cmd_start_i = 0; cmd_len_i = 0;
        cmd_base_a_i = 0; cmd_base_b_i = 0; cmd_base_c_i = 0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "reset cmd_ready", cmd_ready_o, 1);
        check("R1", "reset chunk_valid", chunk_valid_o, 0);
        check("R1", "reset done", done_o, 0);

        for (int pass = 0; pass < 2; pass++) begin
            rdy_mode = pass;
            run_cmd(0, 0);
            run_cmd(1, 0);
            run_cmd(5, 0);
            run_cmd(63, 0);
            run_cmd(64, 0);
            run_cmd(65, 0);
            run_cmd(128, 0);
            run_cmd(130, 0);
            run_cmd(200, 77);
            run_cmd(1000, 3);
            run_cmd(4097, 0);
        end
        rdy_mode = 1;
        for (int i = 0; i < 10; i++) run_cmd(int'($urandom % 3000), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule